// File: doc/BRIEF.md
# Half-Duplex Serial Frame Receiver

This block receives framed characters from one shared, half-duplex serial data line. A separate bit-clock enable `bitTick` marks when the line is sampled. `lineIn` is assumed to be synchronous to `clk` already. A frame is 12 bit times long:

- a low start bit;
- eight data bits, least significant bit first;
- one even-parity bit;
- two high stop bits.

A good byte is delivered with a one-cycle strobe. Faulty frames raise parity-error or framing-error pulses instead.

A line held low for a whole frame is a BREAK. How a BREAK is reported depends on the `txMode` input, which tells the block whether the link currently drives the line or listens to it. In receive mode a BREAK is reported as such. In transmit mode it is reported as a data collision. A BREAK that follows an earlier BREAK, with high line time between them, is always reported as a BREAK. This gives the far end a reliable way to force a BREAK whatever direction the link was in.

After any faulty frame or BREAK the receiver refuses new start bits until it has sampled the line high. After a good frame it accepts a start bit on the very next tick, so frames may be sent back to back.

Top module: `hdx_frame_rx`

## Requirements
- R1: On a tick in idle, a low sample starts a frame. The next eight ticks shift in data least significant bit first, so the first data bit sampled lands in `rxData[0]`.
- R2: The ninth sample after the start is the parity bit. `parityErr` pulses when that bit differs from the XOR of the eight data bits (even parity).
- R3: The tenth and eleventh samples after the start are stop bits. `frameErr` pulses if either stop bit is sampled low.
- R4: `rxValid` pulses and `rxData` takes the new byte only when parity is correct and both stop bits are high. Otherwise `rxData` keeps its old value.
- R5: A BREAK is twelve consecutive low samples from the start bit onward. In transmit mode (`txMode`=1) a BREAK pulses `collision` and not `breakDet`, unless R7 applies.
- R6: In receive mode (`txMode`=0) a BREAK pulses `breakDet` and not `collision`. A BREAK never pulses `parityErr`, `frameErr` or `rxValid`.
- R7: A BREAK that directly follows a previous BREAK, with at least one high sample between them, pulses `breakDet` whatever the mode. Any completed non-BREAK frame cancels this.
- R8: After a parity error, framing error or BREAK, low samples are ignored until one high sample is seen. After a good frame, a low sample on the next tick starts a new frame at once.
- R9: Every result output is a single-cycle pulse. It appears in the clock cycle right after the clock edge that samples the second stop bit.
- R10: Out of reset all pulse outputs are low and `rxData` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle enable: sample the line on this cycle |
| lineIn | input | 1 | Receive side of the shared data line, idle high |
| txMode | input | 1 | 1 = link is in transmit direction, 0 = receive |
| rxData | output | 8 | Last byte received without error |
| rxValid | output | 1 | Pulse: `rxData` was just updated |
| parityErr | output | 1 | Pulse: parity mismatch in the frame just ended |
| frameErr | output | 1 | Pulse: a stop bit was low |
| breakDet | output | 1 | Pulse: BREAK recognised |
| collision | output | 1 | Pulse: BREAK seen while transmitting |

## Verification
Every result of a frame is due exactly one clock after the edge that samples the second stop bit. The bench holds each tick for one cycle, and samples all outputs one nanosecond after each rising edge into per-output event counters. When a frame ends, the bench compares how far each counter moved against the expected outcome. This confirms that each frame produced exactly one pulse of the right kind and that nothing fired in mid-frame.

Ignored stimuli are checked the same way. Low time while the receiver waits for a high sample must leave every counter unchanged.

// File: rtl/hdx_rx_pkg.sv
package hdx_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE      = 2'd0,
    RX_FRAME     = 2'd1,
    RX_WAIT_HIGH = 2'd2
  } rxState_e;

  // Per-tick strobes from control to datapath
  typedef struct packed {
    logic startFrame;
    logic shiftData;
    logic takeParity;
    logic takeStop;
    logic lastBit;
  } rxStrobe_t;

endpackage

// File: rtl/hdx_rx_ctrl.sv
module hdx_rx_ctrl
  import hdx_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitTick,
  input  logic      lineIn,
  input  logic      frameBad,
  output rxStrobe_t strb
);

  localparam int FRAME_BITS = 1 + DATA_BITS + 1 + STOP_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DATA_BITS);
  localparam logic [IDX_W-1:0] PAR_IDX   = IDX_W'(DATA_BITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);

  rxState_e         state;
  logic [IDX_W-1:0] bitIdx;

  always_comb begin
    strb = '0;
    case (state)
      RX_IDLE: begin
        if (bitTick && !lineIn) strb.startFrame = 1'b1;
      end
      RX_FRAME: begin
        if (bitTick) begin
          if (bitIdx <= LAST_DATA)   strb.shiftData  = 1'b1;
          else if (bitIdx == PAR_IDX) strb.takeParity = 1'b1;
          else                        strb.takeStop   = 1'b1;
          if (bitIdx == LAST_IDX)     strb.lastBit    = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      bitIdx <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (strb.startFrame) begin
            state  <= RX_FRAME;
            bitIdx <= IDX_W'(1);
          end
        end
        RX_FRAME: begin
          if (strb.lastBit) begin
            state  <= frameBad ? RX_WAIT_HIGH : RX_IDLE;
            bitIdx <= '0;
          end else if (bitTick) begin
            bitIdx <= bitIdx + IDX_W'(1);
          end
        end
        RX_WAIT_HIGH: begin
          if (bitTick && lineIn) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hdx_rx_datapath.sv
module hdx_rx_datapath
  import hdx_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineIn,
  input  logic                 txMode,
  input  rxStrobe_t            strb,
  output logic                 frameBad,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 frameErr,
  output logic                 breakDet,
  output logic                 collision
);

  logic [DATA_BITS-1:0] shiftReg;
  logic                 parBit;
  logic                 stopOk;
  logic                 sawHigh;
  logic                 breakArmed;

  logic isBreak;
  logic parOk;
  logic stopGood;

  // Evaluated while the final stop bit is on the line
  assign isBreak  = !sawHigh && !lineIn;
  assign parOk    = ((^shiftReg) == parBit);
  assign stopGood = stopOk && lineIn;
  assign frameBad = !parOk || !stopGood;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      parBit     <= 1'b0;
      stopOk     <= 1'b1;
      sawHigh    <= 1'b1;
      breakArmed <= 1'b0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      breakDet   <= 1'b0;
      collision  <= 1'b0;
    end else begin
      rxValid   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakDet  <= 1'b0;
      collision <= 1'b0;

      if (strb.startFrame) begin
        sawHigh <= 1'b0;
        stopOk  <= 1'b1;
      end
      if (strb.shiftData) begin
        shiftReg <= {lineIn, shiftReg[DATA_BITS-1:1]};
        sawHigh  <= sawHigh | lineIn;
      end
      if (strb.takeParity) begin
        parBit  <= lineIn;
        sawHigh <= sawHigh | lineIn;
      end
      if (strb.takeStop && !strb.lastBit) begin
        stopOk  <= stopOk & lineIn;
        sawHigh <= sawHigh | lineIn;
      end

      if (strb.lastBit) begin
        if (isBreak) begin
          breakArmed <= 1'b1;
          if (breakArmed || !txMode) breakDet  <= 1'b1;
          else                       collision <= 1'b1;
        end else begin
          breakArmed <= 1'b0;
          parityErr  <= !parOk;
          frameErr   <= !stopGood;
          if (parOk && stopGood) begin
            rxValid <= 1'b1;
            rxData  <= shiftReg;
          end
        end
      end
    end
  end

endmodule

// File: rtl/hdx_frame_rx.sv
module hdx_frame_rx
  import hdx_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic                 lineIn,
  input  logic                 txMode,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 frameErr,
  output logic                 breakDet,
  output logic                 collision
);

  rxStrobe_t strb;
  logic      frameBad;

  hdx_rx_ctrl #(
    .DATA_BITS(DATA_BITS),
    .STOP_BITS(STOP_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitTick  (bitTick),
    .lineIn   (lineIn),
    .frameBad (frameBad),
    .strb     (strb)
  );

  hdx_rx_datapath #(
    .DATA_BITS(DATA_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .lineIn    (lineIn),
    .txMode    (txMode),
    .strb      (strb),
    .frameBad  (frameBad),
    .rxData    (rxData),
    .rxValid   (rxValid),
    .parityErr (parityErr),
    .frameErr  (frameErr),
    .breakDet  (breakDet),
    .collision (collision)
  );

endmodule

// File: rtl/hdx_frame_rx_chk.sv
module hdx_frame_rx_chk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic txMode,
  input logic rxValid,
  input logic parityErr,
  input logic frameErr,
  input logic breakDet,
  input logic collision
);

  // R4: a delivered byte carries no error or break indication
  a_r4_valid_clean: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !parityErr && !frameErr && !breakDet && !collision);

  // R6: a break is reported one way only
  a_r6_break_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    !(breakDet && collision));

  // R5: a collision needs the transmit direction at the final sample
  a_r5_collision_in_tx: assert property (@(posedge clk) disable iff (!rstN)
    collision |-> $past(txMode));

  // R9: results follow a sampling tick
  a_r9_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid || parityErr || frameErr || breakDet || collision) |-> $past(bitTick));

  // R9: single-cycle pulses
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  a_r9_brk_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (breakDet || collision) |=> !(breakDet || collision));

endmodule

bind hdx_frame_rx hdx_frame_rx_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitTick   (bitTick),
  .txMode    (txMode),
  .rxValid   (rxValid),
  .parityErr (parityErr),
  .frameErr  (frameErr),
  .breakDet  (breakDet),
  .collision (collision)
);

// File: tb/hdx_frame_rx_tb.sv
module hdx_frame_rx_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic lineIn = 1'b1;
  logic txMode = 1'b0;
  logic [7:0] rxData;
  logic rxValid, parityErr, frameErr, breakDet, collision;

  int total = 0;
  int bad = 0;
  int nValid = 0, nPar = 0, nFrm = 0, nBrk = 0, nCol = 0;
  int sV, sP, sF, sB, sC;

  always #4 clk = ~clk;

  hdx_frame_rx u_dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .lineIn(lineIn), .txMode(txMode),
    .rxData(rxData), .rxValid(rxValid), .parityErr(parityErr), .frameErr(frameErr),
    .breakDet(breakDet), .collision(collision)
  );

  // Event counters sampled just after each rising edge
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      if (rxValid)   nValid++;
      if (parityErr) nPar++;
      if (frameErr)  nFrm++;
      if (breakDet)  nBrk++;
      if (collision) nCol++;
    end
  end

  task automatic sendBit(input logic b);
    @(negedge clk);
    lineIn  = b;
    bitTick = 1'b1;
    @(negedge clk);
    bitTick = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic flipPar,
                           input logic s1, input logic s2);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    sendBit((^d) ^ flipPar);
    sendBit(s1);
    sendBit(s2);
  endtask

  task automatic sendBreak();
    for (int i = 0; i < 12; i++) sendBit(1'b0);
  endtask

  task automatic snap();
    sV = nValid; sP = nPar; sF = nFrm; sB = nBrk; sC = nCol;
  endtask

  // Expected counter steps: valid, parity, frame, break, collision
  task automatic expectEv(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {nValid - sV == 1, nPar - sP == 1, nFrm - sF == 1, nBrk - sB == 1, nCol - sC == 1};
    total++;
    if (act != exp || (nValid - sV) > 1 || (nPar - sP) > 1 || (nFrm - sF) > 1 ||
        (nBrk - sB) > 1 || (nCol - sC) > 1) begin
      bad++;
      $display("FAIL %s events(v,p,f,b,c) actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic expectData(input string tag, input logic [7:0] exp);
    total++;
    if (rxData !== exp) begin
      bad++;
      $display("FAIL %s rxData actual=%h expected=%h", tag, rxData, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    // R10: reset state
    total++;
    if ({rxValid, parityErr, frameErr, breakDet, collision} !== 5'b0 || rxData !== 8'h00) begin
      bad++;
      $display("FAIL R10 reset actual=%b/%h expected=00000/00",
               {rxValid, parityErr, frameErr, breakDet, collision}, rxData);
    end
    @(negedge clk); rstN = 1'b1;
    sendBit(1'b1);

    // R1 R4 R8: every byte, back to back, mode toggled (no effect on normal frames)
    for (int b = 0; b < 256; b++) begin
      txMode = b[0];
      snap();
      sendFrame(8'(b), 1'b0, 1'b1, 1'b1);
      expectEv("R1_R4", 5'b10000);
      expectData("R1", 8'(b));
    end
    txMode = 1'b0;
    keep = 8'hFF;

    // R2 R4: every byte with wrong parity; rxData must hold
    for (int b = 0; b < 256; b++) begin
      snap();
      sendFrame(8'(b), 1'b1, 1'b1, 1'b1);
      expectEv("R2", 5'b01000);
      expectData("R4_hold", keep);
      sendBit(1'b1);
    end

    // R3: each stop-bit fault pattern
    for (int s = 0; s < 3; s++) begin
      snap();
      sendFrame(8'h3C, 1'b0, s[0], s[1]);
      expectEv("R3", 5'b00100);
      expectData("R3_hold", keep);
      sendBit(1'b1);
    end
    snap();
    sendFrame(8'h81, 1'b1, 1'b0, 1'b1);
    expectEv("R2_R3_both", 5'b01100);
    sendBit(1'b1);

    // R6: break in receive mode
    snap(); sendBreak(); expectEv("R6", 5'b00010);
    sendBit(1'b1);
    // R7: following break in transmit mode is still a break
    txMode = 1'b1;
    snap(); sendBreak(); expectEv("R7_after_rx_break", 5'b00010);
    sendBit(1'b1);
    // cancel by a good frame, then R5
    snap(); sendFrame(8'h5A, 1'b0, 1'b1, 1'b1); expectEv("R7_cancel", 5'b10000);
    snap(); sendBreak(); expectEv("R5", 5'b00001);
    sendBit(1'b1); sendBit(1'b1);
    snap(); sendBreak(); expectEv("R7_second", 5'b00010);
    sendBit(1'b1);
    snap(); sendBreak(); expectEv("R7_third", 5'b00010);
    sendBit(1'b1);
    txMode = 1'b0;
    snap(); sendFrame(8'hC3, 1'b0, 1'b1, 1'b1); expectEv("R4", 5'b10000);
    expectData("R4", 8'hC3);

    // R8: after a frame error with low stop, low time is ignored
    snap(); sendFrame(8'h55, 1'b0, 1'b1, 1'b0); expectEv("R8_setup", 5'b00100);
    snap();
    for (int i = 0; i < 14; i++) sendBit(1'b0);
    expectEv("R8_ignored", 5'b00000);
    sendBit(1'b1);
    snap(); sendFrame(8'hA3, 1'b0, 1'b1, 1'b1); expectEv("R8_resume", 5'b10000);
    expectData("R8", 8'hA3);

    // R9: no result pulse between frames
    snap();
    repeat (5) sendBit(1'b1);
    expectEv("R9_quiet", 5'b00000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule